// File: doc/BRIEF.md
# T1 Transmit Alarm Inserter

This block sits at the end of a T1 transmit path and overlays maintenance alarm signalling onto the outgoing line bitstream one bit at a time. A transmit framer supplies each bit together with its position: whether it is the framing-bit slot, the frame number within the superframe, and the channel and bit index for payload bits. The block also takes a set of static control bits. It returns the bit to send on the line, registered, one clock after the framer presents it.

Two superframe formats are covered. In the 24-frame extended format, the framing slot of every odd frame forms the facility data link. A yellow alarm there is sent as a repeating 16-bit word of eight ones and then eight zeros. In the 12-frame format, a secondary yellow alarm sets the framing bit of the last frame. The block also supports all-ones alarm signalling (AIS) in framed and unframed form. It can replace bits with a loop-up or loop-down code that an external generator supplies. It can send a yellow flag inside channel 24 when the data-link channel mode is on. A framing-keep control puts the normal framing bits back in place under all-ones or loop codes.

Top module: `t1_alarm_inserter`

## Requirements
- R1: While reset is asserted, and at its release, `line_bit` and `line_valid` are 0.
- R2: When `bit_valid` is sampled high, `line_valid` is 1 on the next cycle and `line_bit` carries the processed bit. After a cycle with `bit_valid` low, `line_valid` is 0 and `line_bit` holds its previous value.
- R3: In extended mode (`esf_mode`=1) with `esf_yel_en`=1, and with neither all-ones nor a loop code active, the framing slot of each odd frame (`frame_num` odd, frames counted 1 to 24) carries a 16-bit word of eight ones and then eight zeros. The word moves one place per such slot. While `esf_yel_en` is 0 the word is held at its start, so the first data-link bit after enabling is a one.
- R4: In 12-frame mode (`esf_mode`=0) with `d4_yel_en`=1, the framing bit of frame 12 is sent as 1. The framing bits of frames 1 to 11 pass unchanged. In extended mode `d4_yel_en` has no effect.
- R5: When `ais_n` is 0 and `ais_framed`=0 and `sbit_keep`=0, every output bit is 1, including the framing slot.
- R6: When `ais_n` is 0 and `ais_framed`=1, every payload bit is 1. The framing slot gets the value it would have with AIS inactive and no loop code, yellow overlays included.
- R7: When `ais_n`=1 and `loop_up` or `loop_dn` is 1, every payload bit is replaced by `loop_bit`. The framing slot is also replaced by `loop_bit` unless `sbit_keep`=1.
- R8: When `sbit_keep`=1 and either all-ones or a loop code is active, the framing slot carries `bit_in` unchanged, bypassing any yellow overlay.
- R9: When `dl_mode_en`=1 and `dl_yel_n`=0, bit index 5 of channel 24 (`chan_num`=23, `bit_idx`=5, bits numbered 0 to 7 in transmit order) is sent as 0. This applies only when neither all-ones nor a loop code is active. All other payload bits pass through.
- R10: Priority on payload bits is all-ones first, then loop code, then the channel-24 yellow flag, then `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Clock enable: a line bit is presented this cycle |
| esf_mode | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| fbit_pos | input | 1 | Current bit is the framing-bit slot |
| frame_num | input | 5 | Frame number within superframe, counted from 1 |
| chan_num | input | 5 | Payload channel, 0 to 23 |
| bit_idx | input | 3 | Bit within channel, 0 = first sent |
| bit_in | input | 1 | Normal payload or framing bit from the framer |
| esf_yel_en | input | 1 | Extended-mode data-link yellow alarm enable |
| d4_yel_en | input | 1 | 12-frame mode secondary yellow enable |
| ais_n | input | 1 | All-ones request, active low |
| ais_framed | input | 1 | 1 = framed all-ones, 0 = unframed |
| sbit_keep | input | 1 | Keep normal framing bits under all-ones or loop codes |
| loop_up | input | 1 | Loop-up code insertion active |
| loop_dn | input | 1 | Loop-down code insertion active |
| loop_bit | input | 1 | Current loop code pattern bit |
| dl_mode_en | input | 1 | Data-link channel mode enable |
| dl_yel_n | input | 1 | Channel-24 yellow request, active low |
| line_bit | output | 1 | Bit to line, registered |
| line_valid | output | 1 | `line_bit` was updated this cycle |

## Verification
A bit presented with `bit_valid` high on one clock edge appears on `line_bit` with `line_valid` high right after the next edge. The one exception is reset, whose effect is immediate. The driver works out each expected bit on the falling edge where it applies the stimulus and queues it. It also keeps its own copy of the 16-bit yellow word position. The monitor samples one time unit after every rising edge and takes an item from the queue only when `line_valid` is high, so each comparison lands in the one cycle where that bit is due. Idle gaps are inserted at random into the bit stream. On those cycles the monitor checks instead that `line_valid` is low and that `line_bit` has kept its value.

// File: rtl/t1ai_pkg.sv
package t1ai_pkg;

  // Position classes derived from the framer's counters.
  typedef struct packed {
    logic fdl_slot;     // extended-mode data-link slot (odd frame framing bit)
    logic last_fr_slot; // 12-frame mode framing bit of the last frame
    logic dl_yel_slot;  // channel-24 yellow flag bit position
  } slot_t;

  // Alarm request summary fed into the overlay mux.
  typedef struct packed {
    logic ais;          // all-ones active (already inverted to active high)
    logic ais_framed;
    logic loop;         // any loop code active
    logic keep_f;       // keep framing bits under overriding alarms
    logic esf_yel;
    logic d4_yel;
    logic dl_yel;       // channel-24 yellow active (already inverted)
  } alarm_req_t;

endpackage

// File: rtl/t1ai_slot_decode.sv
module t1ai_slot_decode
  import t1ai_pkg::*;
#(
  parameter int FRM_W       = 5,
  parameter int CH_W        = 5,
  parameter int BIT_W       = 3,
  parameter int D4_LAST_FRM = 12,
  parameter int DL_CHAN     = 23,
  parameter int DL_BIT      = 5
) (
  input  logic             esf_mode,
  input  logic             fbit_pos,
  input  logic [FRM_W-1:0] frame_num,
  input  logic [CH_W-1:0]  chan_num,
  input  logic [BIT_W-1:0] bit_idx,
  output slot_t            slot
);

  localparam logic [FRM_W-1:0] LAST_FRM = D4_LAST_FRM[FRM_W-1:0];
  localparam logic [CH_W-1:0]  YEL_CH   = DL_CHAN[CH_W-1:0];
  localparam logic [BIT_W-1:0] YEL_BIT  = DL_BIT[BIT_W-1:0];

  always_comb begin
    slot.fdl_slot     = esf_mode && fbit_pos && frame_num[0];
    slot.last_fr_slot = !esf_mode && fbit_pos && (frame_num == LAST_FRM);
    slot.dl_yel_slot  = !fbit_pos && (chan_num == YEL_CH) && (bit_idx == YEL_BIT);
  end

endmodule

// File: rtl/t1ai_yel_pattern.sv
module t1ai_yel_pattern #(
  parameter int HALF_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic step,
  output logic pat_bit
);

  localparam int                CNT_W = $clog2(2 * HALF_LEN);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(2 * HALF_LEN - 1);
  localparam logic [CNT_W-1:0]  HALF  = CNT_W'(HALF_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (!enable) begin
      cnt_nxt = '0;
    end else if (step) begin
      cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  generate
    if ((HALF_LEN & (HALF_LEN - 1)) == 0) begin : g_pow2
      assign pat_bit = ~cnt_q[CNT_W-1];
    end else begin : g_cmp
      assign pat_bit = (cnt_q < HALF);
    end
  endgenerate

  // While disabled the word is parked at its first (one) bit.
  assert_pat_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pat_bit);

endmodule

// File: rtl/t1ai_overlay_mux.sv
module t1ai_overlay_mux
  import t1ai_pkg::*;
(
  input  logic       fbit_pos,
  input  logic       bit_in,
  input  logic       loop_bit,
  input  logic       pat_bit,
  input  slot_t      slot,
  input  alarm_req_t req,
  output logic       out_bit
);

  logic f_norm;
  logic p_norm;

  always_comb begin
    // Framing slot with only the yellow overlays applied.
    if (slot.fdl_slot && req.esf_yel) begin
      f_norm = pat_bit;
    end else if (slot.last_fr_slot && req.d4_yel) begin
      f_norm = 1'b1;
    end else begin
      f_norm = bit_in;
    end

    // Payload with only the channel-24 yellow flag applied.
    p_norm = (slot.dl_yel_slot && req.dl_yel) ? 1'b0 : bit_in;

    if (!fbit_pos) begin
      if (req.ais)        out_bit = 1'b1;
      else if (req.loop)  out_bit = loop_bit;
      else                out_bit = p_norm;
    end else begin
      if ((req.ais || req.loop) && req.keep_f) out_bit = bit_in;
      else if (req.ais)   out_bit = req.ais_framed ? f_norm : 1'b1;
      else if (req.loop)  out_bit = loop_bit;
      else                out_bit = f_norm;
    end
  end

endmodule

// File: rtl/t1_alarm_inserter.sv
module t1_alarm_inserter
  import t1ai_pkg::*;
#(
  parameter int FRM_W       = 5,
  parameter int CH_W        = 5,
  parameter int BIT_W       = 3,
  parameter int D4_LAST_FRM = 12,
  parameter int DL_CHAN     = 23,
  parameter int DL_BIT      = 5,
  parameter int YEL_HALF    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             esf_mode,
  input  logic             fbit_pos,
  input  logic [FRM_W-1:0] frame_num,
  input  logic [CH_W-1:0]  chan_num,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             bit_in,
  input  logic             esf_yel_en,
  input  logic             d4_yel_en,
  input  logic             ais_n,
  input  logic             ais_framed,
  input  logic             sbit_keep,
  input  logic             loop_up,
  input  logic             loop_dn,
  input  logic             loop_bit,
  input  logic             dl_mode_en,
  input  logic             dl_yel_n,
  output logic             line_bit,
  output logic             line_valid
);

  localparam logic [FRM_W-1:0] LAST_FRM = D4_LAST_FRM[FRM_W-1:0];
  localparam logic [CH_W-1:0]  YEL_CH   = DL_CHAN[CH_W-1:0];
  localparam logic [BIT_W-1:0] YEL_BIT  = DL_BIT[BIT_W-1:0];

  slot_t      slot;
  alarm_req_t req;
  logic       pat_bit;
  logic       mux_bit;
  logic       bit_q, bit_nxt;
  logic       vld_q, vld_nxt;

  always_comb begin
    req.ais        = !ais_n;
    req.ais_framed = ais_framed;
    req.loop       = loop_up || loop_dn;
    req.keep_f     = sbit_keep;
    req.esf_yel    = esf_yel_en;
    req.d4_yel     = d4_yel_en;
    req.dl_yel     = dl_mode_en && !dl_yel_n;
  end

  t1ai_slot_decode #(
    .FRM_W(FRM_W), .CH_W(CH_W), .BIT_W(BIT_W),
    .D4_LAST_FRM(D4_LAST_FRM), .DL_CHAN(DL_CHAN), .DL_BIT(DL_BIT)
  ) u_decode (
    .esf_mode  (esf_mode),
    .fbit_pos  (fbit_pos),
    .frame_num (frame_num),
    .chan_num  (chan_num),
    .bit_idx   (bit_idx),
    .slot      (slot)
  );

  t1ai_yel_pattern #(.HALF_LEN(YEL_HALF)) u_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (esf_yel_en),
    .step    (bit_valid && slot.fdl_slot),
    .pat_bit (pat_bit)
  );

  t1ai_overlay_mux u_mux (
    .fbit_pos (fbit_pos),
    .bit_in   (bit_in),
    .loop_bit (loop_bit),
    .pat_bit  (pat_bit),
    .slot     (slot),
    .req      (req),
    .out_bit  (mux_bit)
  );

  // Output stage: explicit clock enable on the line bit.
  always_comb begin
    bit_nxt = bit_valid ? mux_bit : bit_q;
    vld_nxt = bit_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign line_bit   = bit_q;
  assign line_valid = vld_q;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> (!line_valid && $stable(line_bit)));

  assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> line_valid);

  assert_last_frame_yel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !esf_mode && fbit_pos && frame_num == LAST_FRM && d4_yel_en
     && ais_n && !loop_up && !loop_dn) |=> line_bit);

  assert_ais_unframed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !ais_n && !ais_framed && !sbit_keep) |=> line_bit);

  assert_loop_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && ais_n && (loop_up || loop_dn) && !fbit_pos)
    |=> (line_bit == $past(loop_bit)));

  assert_ch24_yel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && ais_n && !loop_up && !loop_dn && dl_mode_en && !dl_yel_n
     && !fbit_pos && chan_num == YEL_CH && bit_idx == YEL_BIT) |=> !line_bit);

endmodule

// File: tb/t1_alarm_inserter_tb.sv
module t1_alarm_inserter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_valid, esf_mode, fbit_pos, bit_in;
  logic [4:0] frame_num, chan_num;
  logic [2:0] bit_idx;
  logic       esf_yel_en, d4_yel_en, ais_n, ais_framed, sbit_keep;
  logic       loop_up, loop_dn, loop_bit, dl_mode_en, dl_yel_n;
  logic       line_bit, line_valid;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    ycnt     = 0;
  int    cyc      = 0;
  bit    done     = 1'b0;
  logic  prev_bit = 1'b0;
  string cur_req  = "R2";
  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  t1_alarm_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .esf_mode(esf_mode),
    .fbit_pos(fbit_pos), .frame_num(frame_num), .chan_num(chan_num),
    .bit_idx(bit_idx), .bit_in(bit_in), .esf_yel_en(esf_yel_en),
    .d4_yel_en(d4_yel_en), .ais_n(ais_n), .ais_framed(ais_framed),
    .sbit_keep(sbit_keep), .loop_up(loop_up), .loop_dn(loop_dn),
    .loop_bit(loop_bit), .dl_mode_en(dl_mode_en), .dl_yel_n(dl_yel_n),
    .line_bit(line_bit), .line_valid(line_valid)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: line_bit/valid actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Expected bit, computed from the requirement text.
  function automatic logic model_bit(input logic fb, input int fr, input int ch, input int bi);
    logic ais, loop, f_norm, p_norm, r;
    ais  = !ais_n;
    loop = loop_up || loop_dn;
    if (esf_mode && (fr % 2 == 1) && esf_yel_en) f_norm = (ycnt < 8);   // R3
    else if (!esf_mode && fr == 12 && d4_yel_en) f_norm = 1'b1;         // R4
    else                                         f_norm = bit_in;
    p_norm = (dl_mode_en && !dl_yel_n && ch == 23 && bi == 5) ? 1'b0 : bit_in; // R9
    if (!fb) begin
      if (ais)       r = 1'b1;       // R10 order
      else if (loop) r = loop_bit;
      else           r = p_norm;
    end else begin
      if ((ais || loop) && sbit_keep) r = bit_in;                      // R8
      else if (ais)  r = ais_framed ? f_norm : 1'b1;                   // R5/R6
      else if (loop) r = loop_bit;                                     // R7
      else           r = f_norm;
    end
    return r;
  endfunction

  // Driver: one line bit, pushes its expected value.
  task automatic send_bit(input logic fb, input int fr, input int ch, input int bi);
    fbit_pos  = fb;
    frame_num = 5'(fr);
    chan_num  = 5'(ch);
    bit_idx   = 3'(bi);
    bit_in    = 1'($urandom);
    loop_bit  = 1'($urandom);
    bit_valid = 1'b1;
    if (!esf_yel_en) ycnt = 0;
    exp_q.push_back(model_bit(fb, fr, ch, bi));
    tag_q.push_back(cur_req);
    if (esf_yel_en && esf_mode && fb && (fr % 2 == 1)) ycnt = (ycnt + 1) % 16;
    @(negedge clk);
    bit_valid = 1'b0;
    if (($urandom % 16) == 0) begin
      bit_in = 1'($urandom);
      @(negedge clk);  // idle gap: R2 hold
    end
  endtask

  task automatic run_sf(input int nfr);
    for (int fr = 1; fr <= nfr; fr++) begin
      send_bit(1'b1, fr, 0, 0);
      for (int ch = 0; ch < 24; ch++)
        for (int b = 0; b < 8; b++)
          send_bit(1'b0, fr, ch, b);
    end
  endtask

  task automatic clear_ctrl();
    esf_yel_en = 0; d4_yel_en = 0; ais_n = 1; ais_framed = 0; sbit_keep = 0;
    loop_up = 0; loop_dn = 0; dl_mode_en = 0; dl_yel_n = 1;
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && !done) begin
      if (line_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", line_valid, 1'b0);
        end else begin
          logic e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(line_bit === e, t, line_bit, e);
        end
      end else begin
        check(line_bit === prev_bit, "R2", line_bit, prev_bit);
      end
    end
    prev_bit = line_bit;
    if (cyc > 190000 && !done) begin
      check(1'b0, "watchdog", 1'b0, 1'b1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bit_valid = 0; esf_mode = 0; fbit_pos = 0; bit_in = 1;
    frame_num = 0; chan_num = 0; bit_idx = 0; loop_bit = 1;
    clear_ctrl();
    repeat (3) @(negedge clk);
    check(line_bit === 1'b0 && line_valid === 1'b0, "R1", line_bit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(line_bit === 1'b0 && line_valid === 1'b0, "R1", line_valid, 1'b0);

    cur_req = "R2";  esf_mode = 0; run_sf(12);
    cur_req = "R4";  d4_yel_en = 1; run_sf(12);
    cur_req = "R4";  esf_mode = 1; run_sf(24);
    clear_ctrl();
    cur_req = "R3";  esf_mode = 1; esf_yel_en = 1; run_sf(24); run_sf(7);
    esf_yel_en = 0;  run_sf(2);
    esf_yel_en = 1;  run_sf(24);
    clear_ctrl();
    cur_req = "R5";  esf_mode = 0; ais_n = 0; run_sf(12);
    cur_req = "R6";  ais_framed = 1; d4_yel_en = 1; run_sf(12);
    esf_mode = 1; esf_yel_en = 1; run_sf(24);
    cur_req = "R8";  sbit_keep = 1; run_sf(12);
    clear_ctrl();
    cur_req = "R7";  esf_mode = 0; loop_up = 1; run_sf(12);
    loop_up = 0; loop_dn = 1; run_sf(12);
    cur_req = "R8";  sbit_keep = 1; d4_yel_en = 1; run_sf(12);
    clear_ctrl();
    cur_req = "R9";  dl_mode_en = 1; dl_yel_n = 0; run_sf(12);
    dl_yel_n = 1; run_sf(2);
    cur_req = "R10"; dl_yel_n = 0; loop_up = 1; run_sf(3);
    ais_n = 0; run_sf(3);
    clear_ctrl();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", 1'b0, 1'b0);
    finish_run();
  end

endmodule